// File: doc/BRIEF.md
# Token-Driven Column Data Loader

This block fills a line of per-column pixel codes for a column driver. A single token bit walks along a chain of column positions, one position per data clock. The column that holds the token captures the pixel bus into its slot of a temporary register. The pixel stream itself is never shifted. A latch strobe then copies every temporary slot into an output register in one edge. The output register feeds the pulse generator downstream. The temporary register can therefore collect the next line while the current line is being driven.

The walk runs from the highest active column down to column 0 by default. A direction input reverses the walk. A mode input shortens the chain from the full column count to a reduced count; the columns above the reduced count then sit idle. When the token leaves the last active column, a one-cycle token-out pulse is raised. That pulse is meant for the token input of the next driver in a cascade.

Top module: `token_col_loader`

## Requirements
- R1: When `rst` is high at a clock edge, the token chain, every temporary slot and every output slot are cleared to zero, and `tok_out` goes low.
- R2: With `dir_rev`=0, a `tok_in` pulse sampled at one edge places the token on column ACT-1, where ACT is the active column count. At each of the next ACT edges, the column holding the token captures `pix_in` and the token moves one column down, ending at column 0.
- R3: With `dir_rev`=1, the token enters at column 0 and walks upward, so the k-th captured code (counting from 0) lands in column k.
- R4: With `short_sel`=0 the active count is NUM_COLS. With `short_sel`=1 it is SHORT_COLS, and the columns SHORT_COLS to NUM_COLS-1 are never written and keep their prior contents (zero after reset).
- R5: `tok_out` is high for exactly the one cycle after the edge at which the last active column captured its code. The chain is then empty, so later `pix_in` values are not captured.
- R6: At an edge with `lat` high, every output slot takes the value its temporary slot held before that edge. At all other edges, `out_cols` holds its value.
- R7: While no token is in the chain, the temporary slots keep their contents whatever `pix_in` does.
- R8: A new `tok_in` pulse may be given in the cycle right after `lat`. The next line then fills without disturbing the line that was just latched.
- R9: Column c of `out_cols` occupies bits [c*PIX_W +: PIX_W]. Column 0 is the lowest field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_in | input | 1 | Token injection from the previous driver |
| dir_rev | input | 1 | 0: walk from high column to column 0; 1: walk upward |
| short_sel | input | 1 | 1: reduced active column count |
| pix_in | input | PIX_W | Pixel code bus |
| lat | input | 1 | Copy temporary register to output register |
| tok_out | output | 1 | One-cycle token pass-on to the next driver |
| out_cols | output | NUM_COLS*PIX_W | Output register, one field per column |

## Verification
The bench runs all four combinations of direction and length. A short-mode line is loaded first after reset, so a design that writes the idle upper columns, or that shifts the entry point wrongly, shows a nonzero or misplaced field. The token-out pulse is sampled in the cycle before, the cycle of, and the cycle after its expected position, which catches off-by-one exit timing and a stuck pulse. Garbage is driven on the pixel bus after the walk ends and before a later latch, so a chain that fails to empty corrupts a slot. A reset part-way through a walk, followed by a latch, exposes temporary storage that the reset did not clear.

// File: rtl/colload_pkg.sv
package colload_pkg;

    localparam int DEF_COLS  = 200;
    localparam int DEF_SHORT = 192;
    localparam int DEF_PIX_W = 6;

    typedef enum logic {
        WALK_DOWN = 1'b0,
        WALK_UP   = 1'b1
    } walk_dir_e;

    function automatic int last_col_idx(logic short_sel, int full_n, int short_n);
        return short_sel ? (short_n - 1) : (full_n - 1);
    endfunction

endpackage

// File: rtl/colload_token_chain.sv
module colload_token_chain
    import colload_pkg::*;
#(
    parameter int NUM_COLS   = DEF_COLS,
    parameter int SHORT_COLS = DEF_SHORT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tok_in,
    input  walk_dir_e           dir,
    input  logic                short_sel,
    output logic [NUM_COLS-1:0] tok,
    output logic                tok_out
);

    logic [NUM_COLS-1:0] tok_nxt;
    logic                last_tok;
    logic                exit_tok;

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_pos
        logic from_dn;
        logic from_up;
        logic live;

        if (c == NUM_COLS - 1) begin : g_dn_top
            assign from_dn = tok_in;
        end else if (c == SHORT_COLS - 1) begin : g_dn_short
            assign from_dn = short_sel ? tok_in : tok[c+1];
        end else begin : g_dn_mid
            assign from_dn = tok[c+1];
        end

        if (c == 0) begin : g_up_bot
            assign from_up = tok_in;
        end else begin : g_up_mid
            assign from_up = tok[c-1];
        end

        if (c < SHORT_COLS) begin : g_live_always
            assign live = 1'b1;
        end else begin : g_live_full
            assign live = ~short_sel;
        end

        assign tok_nxt[c] = live & ((dir == WALK_UP) ? from_up : from_dn);
    end

    assign last_tok = tok[last_col_idx(short_sel, NUM_COLS, SHORT_COLS)];
    assign exit_tok = (dir == WALK_UP) ? last_tok : tok[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            tok     <= '0;
            tok_out <= 1'b0;
        end else begin
            tok     <= tok_nxt;
            tok_out <= exit_tok;
        end
    end

endmodule

// File: rtl/colload_temp_store.sv
module colload_temp_store
    import colload_pkg::*;
#(
    parameter int NUM_COLS = DEF_COLS,
    parameter int PIX_W    = DEF_PIX_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_COLS-1:0]            cap,
    input  logic [PIX_W-1:0]               pix,
    output logic [NUM_COLS-1:0][PIX_W-1:0] slots
);

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[c] <= '0;
            end else if (cap[c]) begin
                slots[c] <= pix;
            end
        end
    end

endmodule

// File: rtl/colload_out_store.sv
module colload_out_store
    import colload_pkg::*;
#(
    parameter int NUM_COLS = DEF_COLS,
    parameter int PIX_W    = DEF_PIX_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           lat,
    input  logic [NUM_COLS-1:0][PIX_W-1:0] din,
    output logic [NUM_COLS-1:0][PIX_W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (lat) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/token_col_loader.sv
module token_col_loader
    import colload_pkg::*;
#(
    parameter int NUM_COLS   = DEF_COLS,
    parameter int SHORT_COLS = DEF_SHORT,
    parameter int PIX_W      = DEF_PIX_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tok_in,
    input  logic                      dir_rev,
    input  logic                      short_sel,
    input  logic [PIX_W-1:0]          pix_in,
    input  logic                      lat,
    output logic                      tok_out,
    output logic [NUM_COLS*PIX_W-1:0] out_cols
);

    logic [NUM_COLS-1:0]            tok_vec;
    logic [NUM_COLS-1:0][PIX_W-1:0] temp_slots;
    logic [NUM_COLS-1:0][PIX_W-1:0] held_slots;
    walk_dir_e                      walk_dir;

    assign walk_dir = dir_rev ? WALK_UP : WALK_DOWN;

    colload_token_chain #(
        .NUM_COLS  (NUM_COLS),
        .SHORT_COLS(SHORT_COLS)
    ) u_chain (
        .clk      (clk),
        .rst      (rst),
        .tok_in   (tok_in),
        .dir      (walk_dir),
        .short_sel(short_sel),
        .tok      (tok_vec),
        .tok_out  (tok_out)
    );

    colload_temp_store #(
        .NUM_COLS(NUM_COLS),
        .PIX_W   (PIX_W)
    ) u_temp (
        .clk  (clk),
        .rst  (rst),
        .cap  (tok_vec),
        .pix  (pix_in),
        .slots(temp_slots)
    );

    colload_out_store #(
        .NUM_COLS(NUM_COLS),
        .PIX_W   (PIX_W)
    ) u_out (
        .clk (clk),
        .rst (rst),
        .lat (lat),
        .din (temp_slots),
        .dout(held_slots)
    );

    assign out_cols = held_slots;

endmodule

// File: rtl/colload_checker.sv
module colload_checker #(
    parameter int NUM_COLS   = 200,
    parameter int SHORT_COLS = 192,
    parameter int PIX_W      = 6
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           lat,
    input logic                           short_sel,
    input logic                           tok_in,
    input logic [NUM_COLS-1:0]            tok,
    input logic                           tok_out,
    input logic [NUM_COLS-1:0][PIX_W-1:0] slots,
    input logic [NUM_COLS-1:0][PIX_W-1:0] held
);

    // R1: a reset edge leaves everything cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (tok == '0 && !tok_out && slots == '0 && held == '0));

    // R2: tokens never appear except through injection
    assert_no_spawn_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(tok) <= $past($countones(tok)) + int'($past(tok_in)));

    // R5: a pass-on pulse needs a token that was in the chain
    assert_exit_source_R5: assert property (@(posedge clk) disable iff (rst)
        tok_out |-> $past(tok) != '0);

    // R6: latch copies the temporary register
    assert_lat_copy_R6: assert property (@(posedge clk) disable iff (rst)
        lat |=> held == $past(slots));

    // R6: output register holds without latch
    assert_hold_out_R6: assert property (@(posedge clk) disable iff (rst)
        !lat |=> $stable(held));

    // R7: no token, no change in temporary storage
    assert_hold_temp_R7: assert property (@(posedge clk) disable iff (rst)
        (tok == '0) |=> $stable(slots));

    if (SHORT_COLS < NUM_COLS) begin : g_short
        // R4: idle columns carry no token and are not written
        assert_short_idle_R4: assert property (@(posedge clk) disable iff (rst)
            (short_sel && $past(short_sel)) |->
                (tok[NUM_COLS-1:SHORT_COLS] == '0 &&
                 $stable(slots[NUM_COLS-1:SHORT_COLS])));
    end

endmodule

bind token_col_loader colload_checker #(
    .NUM_COLS  (NUM_COLS),
    .SHORT_COLS(SHORT_COLS),
    .PIX_W     (PIX_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lat      (lat),
    .short_sel(short_sel),
    .tok_in   (tok_in),
    .tok      (tok_vec),
    .tok_out  (tok_out),
    .slots    (temp_slots),
    .held     (held_slots)
);

// File: tb/token_col_loader_bench.sv
module token_col_loader_bench;

    localparam int N = 20;
    localparam int S = 16;
    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst;
    logic         tok_in;
    logic         dir_rev;
    logic         short_sel;
    logic [W-1:0] pix_in;
    logic         lat;
    logic         tok_out;
    logic [N*W-1:0] out_cols;

    always #2 clk = ~clk;

    token_col_loader #(
        .NUM_COLS  (N),
        .SHORT_COLS(S),
        .PIX_W     (W)
    ) u_token_col_loader (
        .clk      (clk),
        .rst      (rst),
        .tok_in   (tok_in),
        .dir_rev  (dir_rev),
        .short_sel(short_sel),
        .pix_in   (pix_in),
        .lat      (lat),
        .tok_out  (tok_out),
        .out_cols (out_cols)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [W-1:0] tmp_m [N];
    logic [W-1:0] held_m [N];

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_out(string req);
        for (int c = 0; c < N; c++) begin
            chk(req, $sformatf("col %0d", c), int'(out_cols[c*W +: W]), int'(held_m[c]));
        end
    endtask

    function automatic logic [W-1:0] pixv(int k, int line);
        return W'((k * 7 + line * 13 + 3) % 64);
    endfunction

    // R2 R3 R4 R5 R6 R8 R9: one full line, then latch
    task automatic load_line(bit rev, bit shrt, int line);
        int act = shrt ? S : N;
        string req = rev ? "R3" : "R2";
        if (shrt) req = {req, "/R4"};
        @(negedge clk);
        dir_rev = rev; short_sel = shrt; tok_in = 1'b1; pix_in = '0; lat = 1'b0;
        for (int k = 0; k < act; k++) begin
            int col = rev ? k : act - 1 - k;
            @(negedge clk);
            tok_in = 1'b0;
            pix_in = pixv(k, line);
            tmp_m[col] = pixv(k, line);
            chk("R5", "tok_out during walk", int'(tok_out), 0);
        end
        @(negedge clk);
        chk("R5", "tok_out pulse", int'(tok_out), 1);
        check_out("R6 hold before lat");
        pix_in = 6'h2A;
        lat = 1'b1;
        @(negedge clk);
        lat = 1'b0;
        chk("R5", "tok_out after pulse", int'(tok_out), 0);
        for (int c = 0; c < N; c++) held_m[c] = tmp_m[c];
        check_out({req, "/R9"});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tok_in = 1'b0; dir_rev = 1'b0; short_sel = 1'b0;
        pix_in = '0; lat = 1'b0;
        for (int c = 0; c < N; c++) begin tmp_m[c] = '0; held_m[c] = '0; end
        repeat (3) @(negedge clk);
        chk("R1", "tok_out reset", int'(tok_out), 0);
        check_out("R1");
        rst = 1'b0;

        load_line(1'b0, 1'b1, 1);
        load_line(1'b1, 1'b1, 2);
        load_line(1'b0, 1'b0, 3);
        load_line(1'b1, 1'b0, 4);
        load_line(1'b0, 1'b1, 5);
        load_line(1'b1, 1'b0, 6);

        // R7: no token, pixel bus toggles, then latch
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            pix_in = W'(k * 11 + 5);
        end
        lat = 1'b1;
        @(negedge clk);
        lat = 1'b0;
        check_out("R7");

        // R8: latch immediately followed by a new line
        load_line(1'b0, 1'b0, 7);
        load_line(1'b0, 1'b0, 8);

        // R1: reset during a walk clears temp storage
        @(negedge clk);
        dir_rev = 1'b0; short_sel = 1'b0; tok_in = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            tok_in = 1'b0;
            pix_in = pixv(k, 9);
        end
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < N; c++) begin tmp_m[c] = '0; held_m[c] = '0; end
        chk("R1", "tok_out mid reset", int'(tok_out), 0);
        check_out("R1 mid reset");
        pix_in = 6'h15;
        lat = 1'b1;
        @(negedge clk);
        lat = 1'b0;
        check_out("R1 temp cleared");

        load_line(1'b1, 1'b1, 10);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule